// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block is the interrupt front end of a small 8-bit processor core. It takes trigger pulses from twelve sources and keeps one pending flag for each. It also holds an enable mask, a priority mask and a global enable. On every clock it picks the request that should be served next. When the core reports that an instruction has finished, the block issues a one-cycle vector request that carries the address of the service routine.

The block keeps one in-service bit for the low level and one for the high level. With these bits, a high-level request can interrupt a low-level routine, and nothing can interrupt a high-level routine. The core sends a pulse when a return-from-interrupt instruction completes. After that pulse, the block lets one more instruction finish before it dispatches again. A build-time mask selects which sources have their pending flag cleared by hardware when they are vectored. Software must clear the flags of all other sources.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A pending flag becomes 1 at the clock edge after its hardware trigger or software set input is 1, whatever the enable state is. If a set and a software clear reach the same flag in the same cycle, the set wins. Otherwise a software clear drops the flag to 0.
- R2: A pending source can be dispatched only when its enable bit and the global enable are both 1. A flag that is pending while the global enable is 0 stays pending and is served once the global enable returns to 1.
- R3: When several sources are eligible at once, any source with priority bit 1 (high) beats every source with priority bit 0 (low). Within the same level, the lowest source index wins.
- R4: The vector request rises only at the clock edge that follows a cycle in which the instruction-done input is 1. It is visible one cycle after the pending flag is, when the instruction-done input is held at 1.
- R5: On the cycle that the vector request is high, the vector address equals 3 + 8 × (winning source index). The vector request lasts one cycle for each dispatch.
- R6: A dispatch sets the in-service bit of the winner's level.
- R7: While the high in-service bit is 1, no dispatch takes place. While only the low in-service bit is 1, only high-level requests can dispatch.
- R8: A return pulse clears the high in-service bit if that bit is set. Otherwise it clears the low in-service bit.
- R9: No dispatch takes place in the cycle of a return pulse. The first instruction-done cycle after a return also dispatches nothing, so the earliest dispatch comes on the second one.
- R10: When a source is dispatched and the auto-clear mask has a 1 for that source, its pending flag is cleared. The flags of unmasked sources stay set.
- R11: Reset clears all pending flags, the enable bits, the priority bits, the global enable, both in-service bits and the vector request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTrig | input | 12 | Hardware trigger pulses, one per source |
| swSet | input | 12 | Software write-one-to-set of pending flags |
| swClr | input | 12 | Software write-one-to-clear of pending flags |
| enWe | input | 1 | Write strobe for the enable mask |
| enData | input | 12 | New enable mask |
| geWe | input | 1 | Write strobe for the global enable |
| geData | input | 1 | New global enable |
| prWe | input | 1 | Write strobe for the priority mask |
| prData | input | 12 | New priority mask (1 = high) |
| instrDone | input | 1 | Core reports that the current instruction has completed |
| retiDone | input | 1 | Core reports that a return-from-interrupt has completed |
| vecReq | output | 1 | One-cycle dispatch strobe |
| vecAddr | output | 16 | Service routine address, valid with vecReq |
| pendFlags | output | 12 | Current pending flags |
| inSvcHi | output | 1 | High-level routine in service |
| inSvcLo | output | 1 | Low-level routine in service |

## Verification
The hardest case to reach from the ports is a preemption followed by a return. This requires a low-level routine in service, a high-level request that overtakes a pending low request with a lower index, and then a return pulse. After that return, the bench must see the first instruction boundary pass with no dispatch and the next boundary dispatch. A directed sequence builds this case step by step: it configures the masks, fires sources in a chosen order, and holds the instruction-done input high so that each boundary falls on a known edge. A long random phase then drives triggers, software writes, boundaries and returns, and compares every cycle against a behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Strobes the control unit sends to the datapath on a dispatch
  typedef struct packed {
    logic loadVec;  // capture the vector address of the current winner
    logic hwClr;    // apply the auto-clear mask to the winner's flag
  } ctrlStrb_t;

endpackage

// File: rtl/irq_prienc.sv
module irq_prienc #(
  parameter int N    = 12,
  parameter int IDXW = 4
) (
  input  logic [N-1:0]    req,
  output logic            valid,
  output logic [IDXW-1:0] idx
);

  // Lowest set index wins
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int             N        = 12,
  parameter int             IDXW     = 4,
  parameter int             ADDRW    = 16,
  parameter logic [N-1:0]   AUTO_CLR = 12'h021,
  parameter int             VEC_BASE = 3,
  parameter int             VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     srcTrig,
  input  logic [N-1:0]     swSet,
  input  logic [N-1:0]     swClr,
  input  logic             enWe,
  input  logic [N-1:0]     enData,
  input  logic             geWe,
  input  logic             geData,
  input  logic             prWe,
  input  logic [N-1:0]     prData,
  input  ctrlStrb_t        strb,
  output logic [N-1:0]     pendQ,
  output logic             winValid,
  output logic             winHigh,
  output logic [ADDRW-1:0] vecAddr
);

  logic [N-1:0]    enQ, prQ;
  logic            geQ;
  logic [N-1:0]    elig, hiReq, loReq;
  logic            hiValid, loValid;
  logic [IDXW-1:0] hiIdx, loIdx, winIdx;
  logic [N-1:0]    winOh, clrHw;

  assign elig  = pendQ & enQ & {N{geQ}};
  assign hiReq = elig & prQ;
  assign loReq = elig & ~prQ;

  irq_prienc #(.N(N), .IDXW(IDXW)) u_encHi (.req(hiReq), .valid(hiValid), .idx(hiIdx));
  irq_prienc #(.N(N), .IDXW(IDXW)) u_encLo (.req(loReq), .valid(loValid), .idx(loIdx));

  assign winValid = hiValid | loValid;
  assign winHigh  = hiValid;
  assign winIdx   = hiValid ? hiIdx : loIdx;

  generate
    for (genvar g = 0; g < N; g++) begin : gOneHot
      assign winOh[g] = (winIdx == IDXW'(g));
    end
  endgenerate

  assign clrHw = {N{strb.hwClr}} & AUTO_CLR & winOh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= '0;
      enQ     <= '0;
      prQ     <= '0;
      geQ     <= 1'b0;
      vecAddr <= '0;
    end else begin
      pendQ <= (pendQ & ~swClr & ~clrHw) | srcTrig | swSet;
      if (enWe) enQ <= enData;
      if (prWe) prQ <= prData;
      if (geWe) geQ <= geData;
      if (strb.loadVec)
        vecAddr <= ADDRW'(VEC_BASE) + ADDRW'(winIdx) * ADDRW'(VEC_STEP);
    end
  end

  // R1
  pend_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(srcTrig | swSet)) |=> ((pendQ & $past(srcTrig | swSet)) == $past(srcTrig | swSet)));

  // R2
  win_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> geQ);

  // R3
  level_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !winHigh) |-> ((elig & prQ) == '0));

  // R10
  masked_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hwClr && !(|(srcTrig | swSet))) |=> ((pendQ & $past(clrHw)) == '0));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      instrDone,
  input  logic      retiDone,
  input  logic      winValid,
  input  logic      winHigh,
  output ctrlStrb_t strb,
  output logic      vecReq,
  output logic      inSvcHi,
  output logic      inSvcLo
);

  logic holdOne;   // one instruction must finish after a return
  logic levelOk;
  logic fire;

  assign levelOk = winHigh ? !inSvcHi : (!inSvcHi && !inSvcLo);
  assign fire    = winValid && levelOk && instrDone && !retiDone && !holdOne;

  assign strb.loadVec = fire;
  assign strb.hwClr   = fire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecReq  <= 1'b0;
      holdOne <= 1'b0;
      inSvcHi <= 1'b0;
      inSvcLo <= 1'b0;
    end else begin
      vecReq <= fire;

      if (retiDone)       holdOne <= 1'b1;
      else if (instrDone) holdOne <= 1'b0;

      if (fire && winHigh)            inSvcHi <= 1'b1;
      else if (retiDone && inSvcHi)   inSvcHi <= 1'b0;

      if (fire && !winHigh)           inSvcLo <= 1'b1;
      else if (retiDone && !inSvcHi)  inSvcLo <= 1'b0;
    end
  end

  // R4
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> $past(instrDone));

  // R6
  svc_marked_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> (inSvcHi || inSvcLo));

  // R7
  hi_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> !$past(inSvcHi));

  // R8
  reti_hi_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retiDone && inSvcHi) |=> (!inSvcHi && (inSvcLo == $past(inSvcLo))));

  // R9
  reti_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecReq |-> (!$past(retiDone) && !$past(holdOne)));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int                 N_SRC         = 12,
  parameter int                 ADDR_W        = 16,
  parameter logic [N_SRC-1:0]   AUTO_CLR_MASK = 12'h021,
  parameter int                 VEC_BASE      = 3,
  parameter int                 VEC_STEP      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_SRC-1:0]  srcTrig,
  input  logic [N_SRC-1:0]  swSet,
  input  logic [N_SRC-1:0]  swClr,
  input  logic              enWe,
  input  logic [N_SRC-1:0]  enData,
  input  logic              geWe,
  input  logic              geData,
  input  logic              prWe,
  input  logic [N_SRC-1:0]  prData,
  input  logic              instrDone,
  input  logic              retiDone,
  output logic              vecReq,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [N_SRC-1:0]  pendFlags,
  output logic              inSvcHi,
  output logic              inSvcLo
);

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  ctrlStrb_t strb;
  logic      winValid, winHigh;

  irq_datapath #(
    .N(N_SRC), .IDXW(IDX_W), .ADDRW(ADDR_W), .AUTO_CLR(AUTO_CLR_MASK),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcTrig(srcTrig), .swSet(swSet), .swClr(swClr),
    .enWe(enWe), .enData(enData), .geWe(geWe), .geData(geData),
    .prWe(prWe), .prData(prData), .strb(strb), .pendQ(pendFlags),
    .winValid(winValid), .winHigh(winHigh), .vecAddr(vecAddr)
  );

  irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone), .retiDone(retiDone),
    .winValid(winValid), .winHigh(winHigh), .strb(strb), .vecReq(vecReq),
    .inSvcHi(inSvcHi), .inSvcLo(inSvcLo)
  );

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;
  localparam logic [N-1:0] MASK = 12'h021;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] srcTrig = '0, swSet = '0, swClr = '0, enData = '0, prData = '0;
  logic enWe = 1'b0, geWe = 1'b0, geData = 1'b0, prWe = 1'b0;
  logic instrDone = 1'b0, retiDone = 1'b0;
  logic vecReq, inSvcHi, inSvcLo;
  logic [15:0] vecAddr;
  logic [N-1:0] pendFlags;

  int total = 0, bad = 0, reqSeen = 0, cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.AUTO_CLR_MASK(MASK)) u_dut (
    .clk(clk), .rstN(rstN), .srcTrig(srcTrig), .swSet(swSet), .swClr(swClr),
    .enWe(enWe), .enData(enData), .geWe(geWe), .geData(geData),
    .prWe(prWe), .prData(prData), .instrDone(instrDone), .retiDone(retiDone),
    .vecReq(vecReq), .vecAddr(vecAddr), .pendFlags(pendFlags),
    .inSvcHi(inSvcHi), .inSvcLo(inSvcLo)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [N-1:0] mPend, mEn, mPri;
  logic mGe, mHi, mLo, mHold, mReq;
  logic [15:0] mAddr;

  always @(posedge clk) begin : model
    int best;
    logic fire, nHi, nLo;
    logic [N-1:0] nPend;
    if (!rstN) begin
      mPend = '0; mEn = '0; mPri = '0; mGe = 0; mHi = 0; mLo = 0;
      mHold = 0; mReq = 0; mAddr = '0;
    end else begin
      best = -1;
      for (int i = 0; i < N; i++)
        if (best < 0 && mPend[i] && mEn[i] && mGe && mPri[i]) best = i;
      if (best < 0)
        for (int i = 0; i < N; i++)
          if (best < 0 && mPend[i] && mEn[i] && mGe && !mPri[i]) best = i;
      fire = 0;
      if (best >= 0 && instrDone && !retiDone && !mHold && !mHi)
        fire = mPri[best] || !mLo;
      nPend = mPend & ~swClr;
      if (fire && MASK[best]) nPend[best] = 1'b0;
      nPend = nPend | srcTrig | swSet;
      nHi = mHi; nLo = mLo;
      if (fire) begin
        if (mPri[best]) nHi = 1; else nLo = 1;
      end else if (retiDone) begin
        if (mHi) nHi = 0; else nLo = 0;
      end
      if (fire) mAddr = 16'(3 + 8 * best);
      mReq = fire;
      mPend = nPend; mHi = nHi; mLo = nLo;
      if (retiDone) mHold = 1; else if (instrDone) mHold = 0;
      if (enWe) mEn = enData;
      if (prWe) mPri = prData;
      if (geWe) mGe = geData;
    end
  end

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (vecReq) reqSeen++;
      chk(vecReq === mReq, "R4 vecReq", 32'(vecReq), 32'(mReq));
      if (mReq) chk(vecAddr === mAddr, "R5 vecAddr", 32'(vecAddr), 32'(mAddr));
      chk(pendFlags === mPend, "R1 pending", 32'(pendFlags), 32'(mPend));
      chk(inSvcHi === mHi, "R6 inSvcHi", 32'(inSvcHi), 32'(mHi));
      chk(inSvcLo === mLo, "R6 inSvcLo", 32'(inSvcLo), 32'(mLo));
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog R4 act=%0d exp=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(pendFlags == '0 && !vecReq && !inSvcHi && !inSvcLo, "R11 reset",
        {18'd0, pendFlags, inSvcHi, inSvcLo}, 32'd0);

    // R1 flag latches while disabled
    srcTrig = 12'h020;
    @(negedge clk); srcTrig = '0;
    chk(pendFlags[5] == 1'b1, "R1 latch disabled", 32'(pendFlags), 32'h020);

    // R2 enabled but global enable off
    enWe = 1; enData = 12'h0AC; instrDone = 1;
    @(negedge clk); enWe = 0;
    repeat (3) @(negedge clk);
    chk(reqSeen == 0, "R2 global off", 32'(reqSeen), 32'd0);

    // R2/R5/R6/R10 global enable on -> dispatch src5
    geWe = 1; geData = 1;
    @(negedge clk); geWe = 0;
    chk(vecReq == 0, "R2 one edge to load", 32'(vecReq), 32'd0);
    @(negedge clk);
    chk(vecReq == 1 && vecAddr == 16'h002B, "R5 addr src5", 32'(vecAddr), 32'h2B);
    chk(inSvcLo == 1, "R6 low marked", 32'(inSvcLo), 32'd1);
    chk(pendFlags[5] == 0, "R10 auto clear", 32'(pendFlags), 32'h0);
    @(negedge clk);
    chk(vecReq == 0, "R5 strobe one cycle", 32'(vecReq), 32'd0);

    // R7 low request blocked while low in service
    prWe = 1; prData = 12'h088; srcTrig = 12'h004;
    @(negedge clk); prWe = 0; srcTrig = '0;
    repeat (3) @(negedge clk);
    chk(reqSeen == 1, "R7 low blocked", 32'(reqSeen), 32'd1);

    // R3 high beats lower-index low; lowest index within high
    srcTrig = 12'h088;
    @(negedge clk); srcTrig = '0;
    @(negedge clk);
    chk(vecReq == 1 && vecAddr == 16'h001B, "R3 winner src3", 32'(vecAddr), 32'h1B);
    chk(inSvcHi == 1, "R6 high marked", 32'(inSvcHi), 32'd1);
    repeat (3) @(negedge clk);
    chk(reqSeen == 2, "R7 nothing under high", 32'(reqSeen), 32'd2);
    chk(pendFlags == 12'h08C, "R10 unmasked kept", 32'(pendFlags), 32'h08C);

    // R8/R9 return from high, then one instruction gap
    swClr = 12'h008; retiDone = 1;
    @(negedge clk); swClr = '0; retiDone = 0;
    chk(!inSvcHi && inSvcLo, "R8 high cleared first", {30'd0, inSvcHi, inSvcLo}, 32'd1);
    chk(vecReq == 0, "R9 no dispatch on return", 32'(vecReq), 32'd0);
    @(negedge clk);
    chk(vecReq == 0, "R9 gap instruction", 32'(vecReq), 32'd0);
    @(negedge clk);
    chk(vecReq == 1 && vecAddr == 16'h003B, "R9 dispatch after gap", 32'(vecAddr), 32'h3B);

    // R8 unwind both levels, clear flags
    instrDone = 0; swClr = '1; retiDone = 1;
    @(negedge clk); @(negedge clk);
    retiDone = 0; swClr = '0;
    chk(!inSvcHi && !inSvcLo, "R8 both cleared", {30'd0, inSvcHi, inSvcLo}, 32'd0);
    instrDone = 1;
    @(negedge clk);

    // R4 minimum latency
    srcTrig = 12'h020;
    @(negedge clk); srcTrig = '0;
    chk(pendFlags[5] == 1 && vecReq == 0, "R4 pending first", 32'(vecReq), 32'd0);
    @(negedge clk);
    chk(vecReq == 1 && vecAddr == 16'h002B, "R4 request next cycle", 32'(vecAddr), 32'h2B);
    retiDone = 1;
    @(negedge clk); retiDone = 0;

    // Random phase against the model
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] t, s, c;
      for (int b = 0; b < N; b++) begin
        t[b] = ($urandom % 20) == 0;
        s[b] = ($urandom % 80) == 0;
        c[b] = ($urandom % 12) == 0;
      end
      srcTrig = t; swSet = s; swClr = c;
      instrDone = ($urandom % 2) == 0;
      retiDone = (mHi || mLo) && (($urandom % 6) == 0);
      enWe = ($urandom % 40) == 0; enData = N'($urandom);
      prWe = ($urandom % 40) == 0; prData = N'($urandom);
      geWe = ($urandom % 50) == 0; geData = ($urandom % 4) != 0;
      @(negedge clk);
    end
    srcTrig = '0; swSet = '0; swClr = '0; enWe = 0; prWe = 0; geWe = 0;
    instrDone = 0; retiDone = 0;
    @(negedge clk);
    summary();
  end

endmodule